// File: doc/BRIEF.md
# Tensor Command Issue Queue

This block sits between a CPU core and its tensor coprocessor. The core issues a coprocessor command by writing a 64-bit value to a control register, and each write is tagged with the id of the hardware thread that made it. Opcodes that need more operand bits also take the 64-bit contents of general register x31, which gives a 128-bit command. The block checks whether the issuing thread may use the opcode. Accepted commands go into a FIFO. From there they leave strictly in arrival order over a valid/ready micro-op port.

An accepted write never holds up the thread while the queue and the counter have room. The dispatched commands run alongside the thread's later instructions. The block counts commands that have been accepted but not yet reported complete. A wait request holds the thread in stall until that count reaches zero. There is no hazard checking between commands, so ordering comes only from the FIFO and from explicit waits. A write that is not allowed is dropped and sets a sticky flag.

Top module: `tcmd_issue_queue`

## Requirements
- R1: After reset, `uop_valid`, `stall`, `illegal_flag` and `pending` are all zero.
- R2: Accepted commands leave on the micro-op port in the order they were written, one per `uop_valid && uop_ready` cycle. The payload stays stable while `uop_ready` is low.
- R3: The opcode is `wr_data[7:0]`. When bit 7 of the opcode is set, the command is extended: `uop_ext` = 1 and `uop_word1` carries the x31 value sampled with the write. Otherwise `uop_ext` = 0 and `uop_word1` = 0. `uop_word0` always equals `wr_data`, and `uop_thread` carries the issuing thread.
- R4: Any write from thread 1 (`wr_thread` = 1) whose opcode is not the L2 prefetch opcode 8'h3C is rejected. It is not enqueued and does not change `pending`.
- R5: A thread-1 write with opcode 8'h3C is accepted only while `l2_scp_en` = 1. With `l2_scp_en` = 0 it is rejected.
- R6: A rejected write sets `illegal_flag`, and the flag stays set until reset.
- R7: A permitted write made while the FIFO holds DEPTH entries raises `stall` and is not taken. It is taken in the first cycle after a slot frees, provided `wr_valid` is held.
- R8: `pending` rises by one on each enqueue and falls by one on each `done` pulse. A `done` pulse while `pending` is zero is ignored. An enqueue and a done pulse in the same cycle leave `pending` unchanged when it is non-zero.
- R9: While `wait_req` is high and `pending` is non-zero, `stall` is high. With `pending` at zero, `wait_req` does not stall.
- R10: A permitted write with a free FIFO slot and `pending` below its maximum is taken in the cycle it is presented, with `stall` low.
- R11: While `pending` equals its maximum (2^CNT_W − 1), a permitted write raises `stall` and is not taken until a `done` pulse lowers the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command control-register write strobe (held while stalled) |
| wr_thread | input | 1 | Issuing hardware thread id |
| wr_data | input | 64 | Command word; bits [7:0] are the opcode |
| gpr_x31 | input | 64 | Contents of x31 at the write, used by extended opcodes |
| l2_scp_en | input | 1 | Tile L2 is at least partly configured as scratchpad |
| wait_req | input | 1 | Thread requests a wait for coprocessor idle |
| done | input | 1 | One-cycle completion pulse from the coprocessor |
| uop_ready | input | 1 | Coprocessor accepts the head command |
| uop_valid | output | 1 | Head command available |
| uop_thread | output | 1 | Thread that issued the head command |
| uop_ext | output | 1 | Head command is 128 bits wide |
| uop_word0 | output | 64 | Command word of the head command |
| uop_word1 | output | 64 | Extension word (x31) or zero |
| stall | output | 1 | Hold the issuing thread |
| illegal_flag | output | 1 | Sticky: a rejected write was seen |
| pending | output | CNT_W | Commands accepted but not yet completed |

## Verification
The bench builds the block with DEPTH = 4 and CNT_W = 3, so the counter saturates at 7. With those values, filling the FIFO with the consumer held off takes four writes. Driving the outstanding count into saturation takes seven, and a full wait release needs only seven done pulses. The full-queue stall, the saturation stall and the wait stall are therefore each driven and then released in a short run. A scoreboard follows the dispatch order and payloads across both thread ids and both command widths.

// File: rtl/tcmd_pkg.sv
package tcmd_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned OPC_W  = 8;
  localparam logic [OPC_W-1:0] OPC_L2_PREFETCH = 8'h3C;
  localparam int unsigned OPC_EXT_BIT = 7;

  typedef struct packed {
    logic              thread;
    logic              ext;
    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;
  } tcmd_t;

  localparam int unsigned TCMD_W = $bits(tcmd_t);

  function automatic logic [OPC_W-1:0] opc_of(input logic [WORD_W-1:0] data);
    return data[OPC_W-1:0];
  endfunction

  function automatic logic opc_is_ext(input logic [OPC_W-1:0] opc);
    return opc[OPC_EXT_BIT];
  endfunction

  // thread 0 may issue anything; thread 1 only the L2 prefetch with scratchpad present
  function automatic logic issue_permitted(input logic thr,
                                           input logic [OPC_W-1:0] opc,
                                           input logic l2_scp);
    if (!thr) return 1'b1;
    return (opc == OPC_L2_PREFETCH) && l2_scp;
  endfunction

  function automatic tcmd_t pack_cmd(input logic thr,
                                     input logic [WORD_W-1:0] data,
                                     input logic [WORD_W-1:0] x31);
    tcmd_t c;
    c.thread = thr;
    c.ext    = opc_is_ext(opc_of(data));
    c.w0     = data;
    c.w1     = c.ext ? x31 : '0;
    return c;
  endfunction

endpackage

// File: rtl/tcmd_admit.sv
module tcmd_admit
  import tcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_thread,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] gpr_x31,
  input  logic              l2_scp_en,
  input  logic              fifo_full,
  input  logic              cnt_sat,
  output logic              push,
  output logic              reject,
  output logic              room_stall,
  output logic              illegal_flag,
  output tcmd_t             cmd
);

  logic permitted;
  logic no_room;

  always_comb begin
    permitted  = issue_permitted(wr_thread, opc_of(wr_data), l2_scp_en);
    no_room    = fifo_full || cnt_sat;
    push       = wr_valid && permitted && !no_room;
    reject     = wr_valid && !permitted;
    room_stall = wr_valid && permitted && no_room;
    cmd        = pack_cmd(wr_thread, wr_data, gpr_x31);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      illegal_flag <= 1'b0;
    else if (reject) illegal_flag <= 1'b1;
  end

endmodule

// File: rtl/tcmd_fifo.sv
module tcmd_fifo #(
  parameter int unsigned WIDTH = 130,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             empty,
  output logic             full
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (occ == '0);
  assign full      = (occ == FULL_OCC);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign head_data = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slot[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/tcmd_outstanding.sv
module tcmd_outstanding #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             done,
  input  logic             wait_req,
  output logic [CNT_W-1:0] count,
  output logic             sat,
  output logic             done_ok,
  output logic             wait_stall
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic up,
                                                  input logic down);
    case ({up, down})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign sat        = (count == CNT_MAX);
  assign done_ok    = done && (count != '0);
  assign wait_stall = wait_req && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, inc, done_ok);
  end

endmodule

// File: rtl/tcmd_issue_queue.sv
module tcmd_issue_queue
  import tcmd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_thread,
  input  logic [63:0]       wr_data,
  input  logic [63:0]       gpr_x31,
  input  logic              l2_scp_en,
  input  logic              wait_req,
  input  logic              done,
  input  logic              uop_ready,
  output logic              uop_valid,
  output logic              uop_thread,
  output logic              uop_ext,
  output logic [63:0]       uop_word0,
  output logic [63:0]       uop_word1,
  output logic              stall,
  output logic              illegal_flag,
  output logic [CNT_W-1:0]  pending
);

  // named internal events, observed by the bound checker
  logic  enq_fire;
  logic  deq_fire;
  logic  rej_fire;
  logic  room_stall;
  logic  wait_stall;
  logic  fifo_full;
  logic  fifo_empty;
  logic  cnt_sat;
  logic  done_ok;
  tcmd_t new_cmd;
  tcmd_t head_cmd;
  logic [TCMD_W-1:0] head_bits;

  tcmd_admit u_admit (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_thread    (wr_thread),
    .wr_data      (wr_data),
    .gpr_x31      (gpr_x31),
    .l2_scp_en    (l2_scp_en),
    .fifo_full    (fifo_full),
    .cnt_sat      (cnt_sat),
    .push         (enq_fire),
    .reject       (rej_fire),
    .room_stall   (room_stall),
    .illegal_flag (illegal_flag),
    .cmd          (new_cmd)
  );

  tcmd_fifo #(.WIDTH(TCMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (enq_fire),
    .push_data (new_cmd),
    .pop       (deq_fire),
    .head_data (head_bits),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  tcmd_outstanding #(.CNT_W(CNT_W)) u_outstanding (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc        (enq_fire),
    .done       (done),
    .wait_req   (wait_req),
    .count      (pending),
    .sat        (cnt_sat),
    .done_ok    (done_ok),
    .wait_stall (wait_stall)
  );

  assign head_cmd   = tcmd_t'(head_bits);
  assign uop_valid  = !fifo_empty;
  assign deq_fire   = uop_valid && uop_ready;
  assign uop_thread = head_cmd.thread;
  assign uop_ext    = head_cmd.ext;
  assign uop_word0  = head_cmd.w0;
  assign uop_word1  = head_cmd.w1;
  assign stall      = room_stall || wait_stall;

endmodule

// File: rtl/tcmd_issue_queue_chk.sv
module tcmd_issue_queue_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_thread,
  input logic [7:0]       wr_opc,
  input logic             l2_scp_en,
  input logic             wait_req,
  input logic             stall,
  input logic             illegal_flag,
  input logic [CNT_W-1:0] pending,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [63:0]      uop_word0,
  input logic             enq_fire,
  input logic             fifo_full,
  input logic             cnt_sat,
  input logic             done_ok
);

  a_r2_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_word0));

  a_r4_thread1_only_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_thread && (wr_opc != 8'h3C) |-> !enq_fire);

  a_r5_prefetch_needs_scp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_thread && !l2_scp_en |-> !enq_fire);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_flag |=> illegal_flag);

  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !enq_fire);

  a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire && !done_ok |=> pending == $past(pending) + 1'b1);

  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && !enq_fire |=> pending == $past(pending) - 1'b1);

  a_r9_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req && (pending != '0) |-> stall);

  a_r11_no_push_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sat |-> !enq_fire);

endmodule

bind tcmd_issue_queue tcmd_issue_queue_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_thread    (wr_thread),
  .wr_opc       (wr_data[7:0]),
  .l2_scp_en    (l2_scp_en),
  .wait_req     (wait_req),
  .stall        (stall),
  .illegal_flag (illegal_flag),
  .pending      (pending),
  .uop_valid    (uop_valid),
  .uop_ready    (uop_ready),
  .uop_word0    (uop_word0),
  .enq_fire     (enq_fire),
  .fifo_full    (fifo_full),
  .cnt_sat      (cnt_sat),
  .done_ok      (done_ok)
);

// File: tb/test_tcmd_issue_queue.sv
module test_tcmd_issue_queue;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_thread = 1'b0, l2_scp_en = 1'b0;
  logic wait_req = 1'b0, done = 1'b0, uop_ready = 1'b0;
  logic [63:0] wr_data = '0, gpr_x31 = '0;
  logic uop_valid, uop_thread, uop_ext, stall, illegal_flag;
  logic [63:0] uop_word0, uop_word1;
  logic [CNT_W-1:0] pending;

  int checks = 0;
  int failures = 0;
  logic [129:0] sb[$];

  always #5 clk = ~clk;

  tcmd_issue_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_tcmd_issue_queue (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_thread(wr_thread),
    .wr_data(wr_data), .gpr_x31(gpr_x31), .l2_scp_en(l2_scp_en),
    .wait_req(wait_req), .done(done), .uop_ready(uop_ready),
    .uop_valid(uop_valid), .uop_thread(uop_thread), .uop_ext(uop_ext),
    .uop_word0(uop_word0), .uop_word1(uop_word1), .stall(stall),
    .illegal_flag(illegal_flag), .pending(pending)
  );

  task automatic check(input string req, input logic [129:0] act, input logic [129:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected payload derived from R3: opcode bit 7 selects the x31 extension
  function automatic logic [129:0] expect_of(input logic thr, input logic [63:0] d,
                                             input logic [63:0] x);
    return {thr, d[7], d, d[7] ? x : 64'h0};
  endfunction

  // monitor: each handshake must match the oldest expected command (R2, R3)
  always @(negedge clk) begin
    if (rst_n && uop_valid && uop_ready) begin
      if (sb.size() == 0) check("R2 unexpected dispatch", {uop_thread, uop_ext, uop_word0, uop_word1}, '0);
      else check("R2/R3 dispatch order+payload", {uop_thread, uop_ext, uop_word0, uop_word1}, sb.pop_front());
    end
  end

  // driver: one write, held while stall is high
  task automatic issue(input logic thr, input logic [63:0] d, input logic [63:0] x, input logic ok);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_thread = thr; wr_data = d; gpr_x31 = x;
    if (ok) sb.push_back(expect_of(thr, d, x));
    @(negedge clk);
    while (stall) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(posedge clk); #1 done = 1'b1;
    @(posedge clk); #1 done = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {uop_valid, stall, illegal_flag, pending}, '0);

    // R2 R3 R10: plain and extended thread-0 commands
    uop_ready = 1'b1;
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_thread = 1'b0; wr_data = 64'h1111_0000_0000_0005; gpr_x31 = 64'hDEAD;
    sb.push_back(expect_of(1'b0, wr_data, gpr_x31));
    @(negedge clk);
    check("R10 no stall on enqueue", stall, 1'b0);
    @(posedge clk); #1 wr_valid = 1'b0;
    issue(1'b0, 64'h2222_0000_0000_0085, 64'hCAFE_F00D_1234_5678, 1'b1);
    issue(1'b0, 64'h3333_0000_0000_00FF, 64'h0BAD_0BAD_0BAD_0BAD, 1'b1);
    @(negedge clk);
    check("R8 pending after three enqueues", pending, 3);
    repeat (3) pulse_done();
    @(negedge clk);
    check("R8 pending back to zero", pending, 0);
    pulse_done();
    @(negedge clk);
    check("R8 done at zero ignored", pending, 0);
    check("R6 flag clear before any reject", illegal_flag, 1'b0);

    // R4: thread 1 non-prefetch rejected
    l2_scp_en = 1'b1;
    issue(1'b1, 64'h0000_0000_0000_0005, 64'h0, 1'b0);
    @(negedge clk);
    check("R4 reject leaves no dispatch", uop_valid, 1'b0);
    check("R4 reject leaves pending", pending, 0);
    check("R6 flag set by reject", illegal_flag, 1'b1);

    // R5: thread 1 prefetch with and without scratchpad
    issue(1'b1, 64'h4444_0000_0000_003C, 64'h9, 1'b1);
    @(negedge clk);
    check("R5 prefetch accepted with scratchpad", pending, 1);
    l2_scp_en = 1'b0;
    issue(1'b1, 64'h5555_0000_0000_003C, 64'h9, 1'b0);
    @(negedge clk);
    check("R5 prefetch rejected without scratchpad", pending, 1);
    issue(1'b0, 64'h6666_0000_0000_0010, 64'h0, 1'b1);
    @(negedge clk);
    check("R6 flag stays after legal write", illegal_flag, 1'b1);
    repeat (2) pulse_done();

    // R7: fill the FIFO with the consumer blocked
    uop_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) issue(1'b0, 64'h7000 + 64'(i), 64'h0, 1'b1);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_thread = 1'b0; wr_data = 64'h0000_0000_0000_0081; gpr_x31 = 64'hABCD;
    sb.push_back(expect_of(1'b0, wr_data, gpr_x31));
    repeat (3) begin
      @(negedge clk);
      check("R7 stall while full", stall, 1'b1);
    end
    check("R7 full write not counted", pending, DEPTH);
    @(posedge clk); #1 uop_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 stall drops after a slot frees", stall, 1'b0);
    @(posedge clk); #1 wr_valid = 1'b0;
    @(negedge clk);
    check("R7 held write taken", pending, DEPTH + 1);

    // R11: drive the counter to saturation (7)
    issue(1'b0, 64'h0000_0000_0000_0021, 64'h0, 1'b1);
    issue(1'b0, 64'h0000_0000_0000_0022, 64'h0, 1'b1);
    repeat (3) @(posedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = 64'h0000_0000_0000_0023;
    sb.push_back(expect_of(1'b0, wr_data, gpr_x31));
    @(negedge clk);
    check("R11 stall at saturation", stall, 1'b1);
    check("R11 nothing dispatched at saturation", uop_valid, 1'b0);
    check("R11 count at max", pending, 7);
    @(posedge clk); #1 done = 1'b1;
    @(posedge clk); #1 done = 1'b0;
    @(negedge clk);
    check("R11 stall released after done", stall, 1'b0);
    @(posedge clk); #1 wr_valid = 1'b0;
    @(negedge clk);
    check("R11 held write taken", pending, 7);

    // R9: wait until idle
    @(posedge clk); #1 wait_req = 1'b1;
    @(negedge clk);
    check("R9 wait stalls while pending", stall, 1'b1);
    @(posedge clk); #1 done = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R9 still stalled at one pending", {stall, pending}, {1'b1, 3'd1});
    @(posedge clk); #1 done = 1'b0;
    @(negedge clk);
    check("R9 wait released at zero", {stall, pending}, {1'b0, 3'd0});
    @(posedge clk); #1 wait_req = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 all expected commands dispatched", 130'(sb.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule